// File: doc/BRIEF.md
# Decode-Stage Operand Bypass with Load-Use Interlock

This block sits in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). The decoding instruction can name up to three source registers: a base operand, a second operand and a shift-amount register. For each one, the block chooses between the register-file value and a result that an older instruction has not yet written back. It compares the source address against the destination held in the execute, memory and writeback stages. A stage counts only when its write-enable is set. When several stages match, the youngest one wins.

A load result is not ready until the end of its memory cycle. If the instruction just behind a load reads the loaded register, the block raises a stall request for one cycle. The stall freezes fetch and decode and places a bubble in the decode/execute register. By the next cycle the load has moved to the memory stage, and its data is then bypassed like any other result. The top register index is the program counter. It is never bypassed. It always reads the pipelined PC value supplied to the block.

The block contains the decode/execute operand register. Forwarded operands therefore appear on its outputs one clock edge after decode, together with a valid flag that is low for a bubble.

Top module: `opnd_bypass`

## Requirements
- R1: During and right after reset, `de_valid` is 0 and `op_a`, `op_b`, `op_c` are all 0.
- R2: When no stage with its write-enable set holds a matching destination, each operand register loads its register-file input on the next edge.
- R3: When the execute stage has `ex_we`=1, `ex_load`=0 and `ex_dst` equal to a source address, that operand loads `ex_data` with no stall. This holds whether or not the source's use bit is set.
- R4: When the memory stage has `mem_we`=1 and a matching `mem_dst`, that operand loads `mem_data` with no stall. This includes a load that is two instructions ahead.
- R5: When the writeback stage has `wb_we`=1 and a matching `wb_dst`, that operand loads `wb_data`.
- R6: Priority is execute over memory over writeback when more than one stage matches the same source.
- R7: A stage whose write-enable is 0 never supplies an operand, even if its destination matches.
- R8: A source address of all ones (register 15 at default width) always loads `pc_val`. It never forwards from any stage and never causes a stall.
- R9: When `dec_valid`=1 and a used source (use bit i set, with bit 0 for a, bit 1 for b, bit 2 for c) matches an execute-stage destination with `ex_we`=1 and `ex_load`=1, `stall` is 1 in that same cycle. On the next edge `de_valid` goes to 0 and all three operands go to 0.
- R10: A source whose use bit is 0 never raises `stall`.
- R11: The three source ports are resolved independently, and each may take a different stage in the same cycle.
- R12: With `dec_valid`=0, `stall` is 0 and the next edge loads a bubble (`de_valid`=0, operands 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| src_use | input | 3 | Per-source use bits {c,b,a} |
| src_a | input | AW | Base operand register address |
| src_b | input | AW | Second operand register address |
| src_c | input | AW | Shift-amount register address |
| rf_a | input | DW | Register-file read value for src_a |
| rf_b | input | DW | Register-file read value for src_b |
| rf_c | input | DW | Register-file read value for src_c |
| pc_val | input | DW | Pipelined PC value read for the PC index |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_dst | input | AW | Execute-stage destination |
| ex_data | input | DW | Execute-stage result |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | AW | Memory-stage destination |
| mem_data | input | DW | Memory-stage result or load data |
| wb_we | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | AW | Writeback-stage destination |
| wb_data | input | DW | Writeback-stage result |
| stall | output | 1 | Freeze fetch/decode and insert a bubble |
| de_valid | output | 1 | Decode/execute register holds a real instruction |
| op_a | output | DW | Registered operand for src_a |
| op_b | output | DW | Registered operand for src_b |
| op_c | output | DW | Registered operand for src_c |

## Verification
`stall` is a combinational result of the current decode and stage inputs. The bench drives inputs on a falling edge and reads `stall` one nanosecond later, before the next rising edge. The operands and `de_valid` pass through the single decode/execute register, so they are due exactly one rising edge after the stimulus. The bench samples them on the following falling edge and then applies the next vector. Each table vector gives an expected source code per port, and the bench maps that code to the data value it drove to that stage.

// File: rtl/opnd_bypass.sv
`timescale 1ns/1ps
module opnd_bypass #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [2:0]    src_use,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic [AW-1:0] src_c,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic [DW-1:0] rf_c,
  input  logic [DW-1:0] pc_val,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] ex_dst,
  input  logic [DW-1:0] ex_data,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_dst,
  input  logic [DW-1:0] mem_data,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_dst,
  input  logic [DW-1:0] wb_data,
  output logic          stall,
  output logic          de_valid,
  output logic [DW-1:0] op_a,
  output logic [DW-1:0] op_b,
  output logic [DW-1:0] op_c
);
  localparam int NP = 3;
  localparam logic [AW-1:0] PC_IDX = '1;

  logic [AW-1:0] src [NP];
  logic [DW-1:0] rfv [NP];
  logic [DW-1:0] pick [NP];
  logic [NP-1:0] ld_hit;

  assign src[0] = src_a;
  assign src[1] = src_b;
  assign src[2] = src_c;
  assign rfv[0] = rf_a;
  assign rfv[1] = rf_b;
  assign rfv[2] = rf_c;

  for (genvar i = 0; i < NP; i++) begin : g_port
    logic is_pc, hit_ex, hit_mem, hit_wb;
    assign is_pc   = (src[i] == PC_IDX);
    assign hit_ex  = !is_pc && ex_we  && (ex_dst  == src[i]);
    assign hit_mem = !is_pc && mem_we && (mem_dst == src[i]);
    assign hit_wb  = !is_pc && wb_we  && (wb_dst  == src[i]);
    assign ld_hit[i] = hit_ex && ex_load;
    assign pick[i] = is_pc   ? pc_val   :
                     hit_ex  ? ex_data  :
                     hit_mem ? mem_data :
                     hit_wb  ? wb_data  : rfv[i];
  end

  assign stall = dec_valid && |(ld_hit & src_use);

  always_ff @(posedge clk) begin
    if (!rst_n || stall || !dec_valid) begin
      de_valid <= 1'b0;
      op_a     <= '0;
      op_b     <= '0;
      op_c     <= '0;
    end else begin
      de_valid <= 1'b1;
      op_a     <= pick[0];
      op_b     <= pick[1];
      op_c     <= pick[2];
    end
  end
endmodule

// File: rtl/opnd_bypass_chk.sv
`timescale 1ns/1ps
module opnd_bypass_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_valid,
  input logic [2:0]    src_use,
  input logic [AW-1:0] src_a,
  input logic [DW-1:0] pc_val,
  input logic          ex_we,
  input logic          ex_load,
  input logic [AW-1:0] ex_dst,
  input logic [DW-1:0] ex_data,
  input logic          stall,
  input logic          de_valid,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic [DW-1:0] op_c
);
  localparam logic [AW-1:0] PC_IDX = '1;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !de_valid && op_a == '0);

  p_ex_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !stall && ex_we && !ex_load && ex_dst == src_a && src_a != PC_IDX
    |=> de_valid && op_a == $past(ex_data));

  p_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !stall && src_a == PC_IDX |=> op_a == $past(pc_val));

  p_load_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && src_use[0] && src_a != PC_IDX && ex_we && ex_load && ex_dst == src_a
    |-> stall);

  p_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !de_valid && op_a == '0 && op_b == '0 && op_c == '0);

  p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    src_use == 3'b000 |-> !stall);

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !stall);

  p_issue_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !stall |=> de_valid);
endmodule

bind opnd_bypass opnd_bypass_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .src_use(src_use),
  .src_a(src_a), .pc_val(pc_val), .ex_we(ex_we), .ex_load(ex_load),
  .ex_dst(ex_dst), .ex_data(ex_data), .stall(stall), .de_valid(de_valid),
  .op_a(op_a), .op_b(op_b), .op_c(op_c)
);

// File: tb/opnd_bypass_tb.sv
`timescale 1ns/1ps
module opnd_bypass_tb;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam logic [DW-1:0] RFB = 32'hA000_0000;
  localparam logic [DW-1:0] EXD = 32'hE1E1_0001;
  localparam logic [DW-1:0] MMD = 32'h3E3E_0002;
  localparam logic [DW-1:0] WBD = 32'hB0B0_0003;
  localparam logic [DW-1:0] PCV = 32'h0000_0108;

  logic clk = 0, rst_n = 0, dec_valid = 0;
  logic [2:0] src_use = 0;
  logic [AW-1:0] src_a = 0, src_b = 0, src_c = 0, ex_dst = 0, mem_dst = 0, wb_dst = 0;
  logic ex_we = 0, ex_load = 0, mem_we = 0, wb_we = 0;
  logic stall, de_valid;
  logic [DW-1:0] op_a, op_b, op_c;
  int checks = 0, failures = 0, cyc = 0;

  always #5 clk = ~clk;

  opnd_bypass #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .src_use(src_use),
    .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .rf_a(RFB), .rf_b(RFB + 1), .rf_c(RFB + 2), .pc_val(PCV),
    .ex_we(ex_we), .ex_load(ex_load), .ex_dst(ex_dst), .ex_data(EXD),
    .mem_we(mem_we), .mem_dst(mem_dst), .mem_data(MMD),
    .wb_we(wb_we), .wb_dst(wb_dst), .wb_data(WBD),
    .stall(stall), .de_valid(de_valid), .op_a(op_a), .op_b(op_b), .op_c(op_c)
  );

  // expected source codes: 0 regfile, 1 execute, 2 memory, 3 writeback, 4 pc, 5 bubble
  typedef struct packed {
    logic [3:0] rq;
    logic       dv;
    logic [2:0] um;
    logic [3:0] sa, sb, sc;
    logic       ewe, eld;
    logic [3:0] ed;
    logic       mwe;
    logic [3:0] md;
    logic       wwe;
    logic [3:0] wd;
    logic       st;
    logic [2:0] ea, eb, ec;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{2,  1, 7, 1, 2, 3,  0, 0, 0,  0, 0,  0, 0,  0,  0, 0, 0},  // R2
    '{3,  1, 7, 1, 2, 3,  1, 0, 1,  0, 0,  0, 0,  0,  1, 0, 0},  // R3
    '{4,  1, 7, 1, 2, 3,  0, 0, 0,  1, 2,  0, 0,  0,  0, 2, 0},  // R4
    '{5,  1, 7, 1, 2, 3,  0, 0, 0,  0, 0,  1, 3,  0,  0, 0, 3},  // R5
    '{6,  1, 7, 1, 2, 3,  1, 0, 1,  1, 1,  1, 1,  0,  1, 0, 0},  // R6 ex over mem
    '{6,  1, 7, 1, 2, 3,  0, 0, 0,  1, 2,  1, 2,  0,  0, 2, 0},  // R6 mem over wb
    '{7,  1, 7, 1, 2, 3,  0, 0, 1,  0, 2,  0, 3,  0,  0, 0, 0},  // R7
    '{8,  1, 7, 15, 2, 3, 1, 0, 15, 1, 15, 1, 15, 0,  4, 0, 0},  // R8
    '{9,  1, 7, 1, 2, 3,  1, 1, 2,  0, 0,  0, 0,  1,  5, 5, 5},  // R9 on b
    '{10, 1, 3, 1, 4, 2,  1, 1, 2,  0, 0,  0, 0,  0,  0, 0, 1},  // R10
    '{11, 1, 7, 1, 2, 3,  1, 0, 1,  1, 2,  1, 3,  0,  1, 2, 3},  // R11
    '{12, 0, 7, 1, 2, 3,  1, 1, 1,  0, 0,  0, 0,  0,  5, 5, 5},  // R12
    '{4,  1, 7, 1, 2, 3,  0, 0, 0,  1, 1,  0, 0,  0,  2, 0, 0},  // R4 load two ahead
    '{8,  1, 7, 15, 2, 3, 1, 1, 15, 0, 0,  0, 0,  0,  4, 0, 0},  // R8 load on pc index
    '{9,  1, 7, 1, 2, 5,  1, 1, 5,  0, 0,  0, 0,  1,  5, 5, 5}   // R9 on c
  };

  function automatic logic [DW-1:0] xv(input logic [2:0] c, input int p);
    case (c)
      3'd0: return RFB + DW'(p);
      3'd1: return EXD;
      3'd2: return MMD;
      3'd3: return WBD;
      3'd4: return PCV;
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    dec_valid = v.dv; src_use = v.um;
    src_a = v.sa; src_b = v.sb; src_c = v.sc;
    ex_we = v.ewe; ex_load = v.eld; ex_dst = v.ed;
    mem_we = v.mwe; mem_dst = v.md; wb_we = v.wwe; wb_dst = v.wd;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=5000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 de_valid", DW'(de_valid), '0);
    chk("R1 op_a", op_a, '0);
    chk("R1 stall", DW'(stall), '0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      #1;
      chk($sformatf("R%0d stall v%0d", VT[i].rq, i), DW'(stall), DW'(VT[i].st));
      @(negedge clk);
      chk($sformatf("R%0d de_valid v%0d", VT[i].rq, i), DW'(de_valid),
          DW'(VT[i].dv && !VT[i].st));
      chk($sformatf("R%0d op_a v%0d", VT[i].rq, i), op_a, xv(VT[i].ea, 0));
      chk($sformatf("R%0d op_b v%0d", VT[i].rq, i), op_b, xv(VT[i].eb, 1));
      chk($sformatf("R%0d op_c v%0d", VT[i].rq, i), op_c, xv(VT[i].ec, 2));
    end
    // load-use: stall cycle, then load moves to memory stage and is bypassed
    drive(VT[8]);
    @(negedge clk);
    chk("R9 bubble", DW'(de_valid), '0);
    ex_we = 0; ex_load = 0; mem_we = 1; mem_dst = 2;
    #1 chk("R9 stall released", DW'(stall), '0);
    @(negedge clk);
    chk("R4 after interlock", op_b, MMD);
    chk("R4 after interlock valid", DW'(de_valid), 1);
    // R1 reset in mid-run
    rst_n = 0;
    @(negedge clk);
    chk("R1 mid reset valid", DW'(de_valid), '0);
    chk("R1 mid reset op_b", op_b, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule